// File: doc/BRIEF.md
# Lookahead-Driven Thread Issue Gate

This block sits in front of a deep, non-bypassed pipeline shared by many hardware threads. It decides each cycle which thread may send its next instruction, without tracking register dependences. The compiler writes a 3-bit count, 0 to 7, into every instruction. The count tells how many of that thread's following instructions do not depend on it. The gate keeps two values for each thread: the number of instructions still in flight, and the independence credit that remains. From these it raises an eligibility flag for the thread.

A round-robin selector then grants one eligible thread per cycle. If no thread is eligible, the cycle becomes a bubble. Each issued instruction receives a per-thread sequence tag. When the instruction leaves the pipeline, the retirement notice returns the thread number together with that tag. The gate accepts only the notice that matches the oldest in-flight instruction of that thread.

The outputs are combinational from the current thread state and the request inputs. State changes at the clock edge that follows.

Top module: `la_issue_gate`

## Requirements
- R1: After a synchronous reset, every thread has nothing in flight, a credit of 0, and issue and retire tags of 0. The selector pointer rests on the last thread, so thread 0 is the first one granted.
- R2: A thread is eligible exactly when its active bit and its request bit are both set and either it has no instruction in flight or its credit is non-zero. A grant goes only to an eligible thread.
- R3: When a thread issues with nothing in flight, its credit becomes the lookahead value of the issued instruction.
- R4: When a thread issues with instructions already in flight, its credit becomes the smaller of (old credit − 1) and the new lookahead value. While instructions stay in flight, the credit never grows.
- R5: A thread whose credit is 0 and that has instructions in flight stays ineligible until its in-flight count returns to 0. The count never exceeds 8.
- R6: The issue tag is a 4-bit per-thread counter. It starts at 0 and advances by one on each issue of that thread. A retirement is accepted when its thread ID matches, its tag equals that thread's expected retire tag, and the thread has something in flight. Acceptance lowers the in-flight count by one and advances the expected retire tag.
- R7: A retirement whose tag does not match the expected retire tag, or that names a thread with nothing in flight, changes no state.
- R8: The selector grants the first eligible thread in increasing index order, starting after the thread granted most recently and wrapping around. At most one thread is granted per cycle.
- R9: When no thread is eligible, iss_vld is 0, and iss_tid and iss_tag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_act | input | NTHR | Thread active bits |
| thr_req | input | NTHR | Thread has an instruction ready |
| thr_la | input | 3*NTHR | Lookahead of each thread's next instruction; thread t in bits [3t+2:3t] |
| ret_vld | input | 1 | Retirement notice valid |
| ret_tid | input | TIDW | Thread of the retiring instruction |
| ret_tag | input | 4 | Sequence tag of the retiring instruction |
| elig | output | NTHR | Per-thread eligibility flags |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_tid | output | TIDW | Thread granted this cycle |
| iss_tag | output | 4 | Sequence tag given to the issued instruction |

## Verification
One thread is driven through a chain of lookahead values: 2, then 5, then 0. The chain shows the difference between loading the credit on a fresh issue and taking the minimum while instructions are in flight. The gate must close after exactly three issues. A wrong-tag retirement followed by three in-order retirements tells an ignored notice apart from an accepted one. The gate must reopen only after the last of the three. A mix of several requesting threads with different in-flight states, including a thread whose active bit is low, shows that the grant rotates past the last granted thread and that inactive or blocked threads are skipped. A reset in mid-run confirms that thread 0 is again granted first with tag 0.

// File: rtl/la_gate_pkg.sv
package la_gate_pkg;
    localparam int LAW    = 3;
    localparam int MAXOUT = 1 << LAW;
    localparam int OUTW   = $clog2(MAXOUT + 1);
    localparam int SEQW   = LAW + 1;

    typedef logic [LAW-1:0]  la_t;
    typedef logic [OUTW-1:0] out_t;
    typedef logic [SEQW-1:0] seq_t;

    typedef struct packed {
        out_t pend;
        la_t  cred;
        seq_t iseq;
        seq_t rseq;
    } thr_st_t;

    function automatic la_t la_min(la_t a, la_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/ltg_thread.sv
module ltg_thread
    import la_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic req,
    input  la_t  la,
    input  logic grant,
    input  logic ret_hit,
    input  seq_t ret_tag,
    output logic elig,
    output seq_t tag
);
    thr_st_t st, st_n;
    logic    accept;

    assign elig   = act && req && ((st.pend == '0) || (st.cred != '0));
    assign tag    = st.iseq;
    assign accept = ret_hit && (st.pend != '0) && (ret_tag == st.rseq);

    always_comb begin
        st_n = st;
        if (grant) begin
            st_n.iseq = st.iseq + 1'b1;
            st_n.pend = st.pend + 1'b1;
            if (st.pend == '0) st_n.cred = la;
            else               st_n.cred = la_min(st.cred - 1'b1, la);
        end
        if (accept) begin
            st_n.rseq = st.rseq + 1'b1;
            st_n.pend = st_n.pend - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    // R2
    grant_elig_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> elig);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(st.pend) <= MAXOUT);

    // R4
    cred_mono_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st.pend) != '0 && st.pend != '0) |-> st.cred <= $past(st.cred));

    // R7
    bad_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_hit && ret_tag != st.rseq && !grant) |=> $stable(st.pend));
endmodule

// File: rtl/ltg_rr.sv
module ltg_rr #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  gnt,
    output logic          vld,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int off = 1; off <= N; off++) begin
            int k;
            k = int'(ptr) + off;
            if (k >= N) k = k - N;
            if (!vld && elig[k]) begin
                vld = 1'b1;
                idx = IW'(k);
            end
        end
        gnt = vld ? (N'(1) << idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr <= IW'(N - 1);
        else if (vld) ptr <= idx;
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
endmodule

// File: rtl/la_issue_gate.sv
module la_issue_gate
    import la_gate_pkg::*;
#(
    parameter int NTHR = 16,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NTHR-1:0]     thr_act,
    input  logic [NTHR-1:0]     thr_req,
    input  logic [LAW*NTHR-1:0] thr_la,
    input  logic                ret_vld,
    input  logic [TIDW-1:0]     ret_tid,
    input  logic [SEQW-1:0]     ret_tag,
    output logic [NTHR-1:0]     elig,
    output logic                iss_vld,
    output logic [TIDW-1:0]     iss_tid,
    output logic [SEQW-1:0]     iss_tag
);
    logic [NTHR-1:0] gnt;
    seq_t            tag_v [NTHR];

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        ltg_thread u_thr (
            .clk     (clk),
            .rst     (rst),
            .act     (thr_act[g]),
            .req     (thr_req[g]),
            .la      (thr_la[LAW*g +: LAW]),
            .grant   (gnt[g]),
            .ret_hit (ret_vld && (ret_tid == TIDW'(g))),
            .ret_tag (ret_tag),
            .elig    (elig[g]),
            .tag     (tag_v[g])
        );
    end

    ltg_rr #(.N(NTHR)) u_rr (
        .clk  (clk),
        .rst  (rst),
        .elig (elig),
        .gnt  (gnt),
        .vld  (iss_vld),
        .idx  (iss_tid)
    );

    assign iss_tag = iss_vld ? tag_v[iss_tid] : '0;

    // R9
    bubble_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_vld |-> (elig == '0));
endmodule

// File: tb/sim_la_issue_gate.sv
module sim_la_issue_gate;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  thr_act = '0, thr_req = '0;
    logic [11:0] thr_la = '0;
    logic        ret_vld = 1'b0;
    logic [1:0]  ret_tid = '0;
    logic [3:0]  ret_tag = '0;
    logic [3:0]  elig;
    logic        iss_vld;
    logic [1:0]  iss_tid;
    logic [3:0]  iss_tag;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    la_issue_gate #(.NTHR(NT)) u0 (
        .clk(clk), .rst(rst), .thr_act(thr_act), .thr_req(thr_req),
        .thr_la(thr_la), .ret_vld(ret_vld), .ret_tid(ret_tid),
        .ret_tag(ret_tag), .elig(elig), .iss_vld(iss_vld),
        .iss_tid(iss_tid), .iss_tag(iss_tag)
    );

    // {act, req, la t3..t0, rv, rtid, rtag, exp vld, exp tid, exp tag, exp elig}
    localparam int NV = 18;
    localparam logic [37:0] VEC [NV] = '{
        {4'b1111, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0, 4'b0000}, // R9 bubble
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd2, 1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 4'd0, 4'b0001}, // R3 credit=2
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd5, 1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 4'd1, 4'b0001}, // R4 min(1,5)
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 4'd2, 4'b0001}, // R4 min(0,0)
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0, 4'b0000}, // R5 held
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b1, 2'd0, 4'd1, 1'b0, 2'd0, 4'd0, 4'b0000}, // R7 wrong tag
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b1, 2'd0, 4'd0, 1'b0, 2'd0, 4'd0, 4'b0000}, // R6 retire 0
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b1, 2'd0, 4'd1, 1'b0, 2'd0, 4'd0, 4'b0000}, // R6 retire 1
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b1, 2'd0, 4'd2, 1'b0, 2'd0, 4'd0, 4'b0000}, // R5 still held
        {4'b1111, 4'b0001, 3'd0, 3'd0, 3'd0, 3'd7, 1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 4'd3, 4'b0001}, // R5 reopened, R6 tag 3
        {4'b1111, 4'b1011, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd1, 4'd0, 4'b1011}, // R8 after t0
        {4'b1111, 4'b1011, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd3, 4'd0, 4'b1001}, // R8 skip blocked t1
        {4'b1111, 4'b1011, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd0, 4'd4, 4'b0001}, // R8 wrap
        {4'b0111, 4'b1111, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd2, 4'd0, 4'b0100}, // R2 inactive t3
        {4'b1111, 4'b1111, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 2'd1, 4'd0, 1'b0, 2'd0, 4'd0, 4'b0000}, // R9 all blocked
        {4'b1111, 4'b1111, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd1, 4'd1, 4'b0010}, // R6 t1 reopened
        {4'b1111, 4'b1111, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 2'd3, 4'd0, 1'b0, 2'd0, 4'd0, 4'b0000}, // R6 t3 retire
        {4'b1111, 4'b1000, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0, 4'd0, 1'b1, 2'd3, 4'd1, 4'b1000}  // R8 t3 tag 1
    };

    task automatic chk(input string what, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act_v, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            thr_act = v[37:34]; thr_req = v[33:30]; thr_la = v[29:18];
            ret_vld = v[17]; ret_tid = v[16:15]; ret_tag = v[14:11];
            #5;
            chk($sformatf("vec %0d elig R2", i), int'(elig), int'(v[3:0]));
            chk($sformatf("vec %0d vld R8/R9", i), int'(iss_vld), int'(v[10]));
            chk($sformatf("vec %0d tid R8", i), int'(iss_tid), int'(v[9:8]));
            chk($sformatf("vec %0d tag R6", i), int'(iss_tag), int'(v[7:4]));
            @(negedge clk);
        end
        // R1: reset in mid-run clears all state and the pointer
        ret_vld = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        thr_act = 4'b1111; thr_req = 4'b1111; thr_la = '0;
        #5;
        chk("reset elig R1", int'(elig), 15);
        chk("reset vld R1", int'(iss_vld), 1);
        chk("reset tid R1", int'(iss_tid), 0);
        chk("reset tag R1", int'(iss_tag), 0);
        @(negedge clk);
        #5;
        chk("post-reset tid R8", int'(iss_tid), 1);
        chk("post-reset elig R5", int'(elig), 14);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule